// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Emulator

This block is a slave on a Z80-style CPU bus. To a simple monitor program it looks like a two-channel serial controller. It decodes I/O read and write cycles to four byte ports: one data port and one control port for each of channel A and channel B. It does not serialise anything. Bytes that the CPU writes to a data port leave through a valid/ready transmit stream. Bytes that arrive on a valid/ready receive stream wait in a one-byte holding register until the CPU reads them.

Control ports use a two-step scheme. A write with the pointer at zero is a command byte: its low three bits select a register, and one command code resets the channel. The next control access then reaches the selected register, and the pointer goes back to zero. A control read with the pointer at zero returns a status byte with a receive-ready flag and a transmit-empty flag. A received byte raises the active-low interrupt line when the channel's receive interrupt is enabled. When the CPU acknowledges the interrupt, the block drives the vector stored in channel B's register 2 onto the bus.

Settings such as clock rate, character size, parity and modem lines are written into their registers and can be read back. They have no other effect.

Top module: `sio_bus_emu`

## Requirements
- R1: A port access starts only on the first clock with `iorq_n` low, `m1_n` high and `rd_n` or `wr_n` low. It is accepted only when `addr[7:2]` equals `BASE[7:2]`. `addr[0]` selects the channel (0 = A, 1 = B) and `addr[1]` selects control (1) or data (0). With `BASE` = 0 the ports are A data 0x00, B data 0x01, A control 0x02 and B control 0x03. Other addresses are not driven on reads and are ignored on writes.
- R2: With the pointer at 0, a control write loads the pointer from data bits 2:0. With a nonzero pointer, a control write stores the byte in write register N (N = pointer), and a control read returns the stored byte of register N. Either access returns the pointer to 0.
- R3: A command byte whose bits 5:3 equal 011 (for example 0x18) resets the channel. It clears the pointer and write register 1, and it discards any waiting received byte. It leaves the transmit side untouched. If a byte arrives in the same cycle as the reset, that byte is discarded.
- R4: A control read with the pointer at 0 returns a status byte. Bit 0 is 1 while a received byte waits. Bit 2 is 1 while the transmit holding register is empty. All other bits are 0.
- R5: A data-port write into an empty transmit holder loads the byte. `tx_valid` then stays high, with the byte held on `tx_data`, until a cycle with `tx_ready` high. A write while the holder is full and not being drained is dropped. A write in the same cycle as a drain loads the new byte.
- R6: `rx_ready` is high exactly when no received byte waits. A valid/ready handshake stores the byte. A data-port read returns the byte and frees the holder.
- R7: `int_n` is low exactly while some channel has a byte waiting and bits 4:3 of that channel's write register 1 are not both 0.
- R8: An interrupt acknowledge is the start of a cycle with `m1_n` and `iorq_n` both low. If `int_n` is low at that point, the block drives channel B's write register 2 on `dout`. Otherwise it drives nothing.
- R9: Cycles with `iorq_n` high, including instruction fetches (`m1_n` and `rd_n` low), neither drive the bus nor change any state.
- R10: `doe` rises one clock after a read or acknowledge cycle starts. `dout` then holds the value captured at that start for the whole cycle. `doe` falls one clock after `iorq_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Machine cycle one, active low |
| addr | input | 8 | Low address byte |
| din | input | 8 | Data from the CPU |
| dout | output | 8 | Data to the CPU |
| doe | output | 1 | Drive enable for `dout` |
| int_n | output | 1 | Interrupt request, active low |
| tx_data | output | 16 | Transmit bytes, channel A in bits 7:0 |
| tx_valid | output | 2 | Transmit byte held, one bit per channel |
| tx_ready | input | 2 | Transmit sink accepts the byte |
| rx_data | input | 16 | Received bytes, channel A in bits 7:0 |
| rx_valid | input | 2 | Received byte offered |
| rx_ready | output | 2 | Receive holder empty |

## Verification
The transmit holder can be drained by the sink and refilled by a CPU data write in the same clock. The bench provokes this by holding `tx_ready` low with a byte pending, then raising it on the same edge that starts the next data write. It judges the result by checking that `tx_valid` stays high and that `tx_data` shows the new byte afterwards. A second coincidence is handled the same way: a receive handshake lands on the edge of a channel-reset command. That case is judged by `rx_ready` returning high and the status byte showing no waiting character.

// File: rtl/sio_bus_emu.sv
module sio_bus_emu #(
  parameter logic [7:0] BASE = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        iorq_n,
  input  logic        rd_n,
  input  logic        wr_n,
  input  logic        m1_n,
  input  logic [7:0]  addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        doe,
  output logic        int_n,
  output logic [15:0] tx_data,
  output logic [1:0]  tx_valid,
  input  logic [1:0]  tx_ready,
  input  logic [15:0] rx_data,
  input  logic [1:0]  rx_valid,
  output logic [1:0]  rx_ready
);
  localparam int NCH = 2;
  localparam int DW = 8;
  localparam int VCH = 1;
  localparam logic [2:0] RST_CMD = 3'b011;

  logic           busy_q, hold_q;
  logic [DW-1:0]  rdat_q, rd_val;
  logic [2:0]     ptr_q  [NCH];
  logic [DW-1:0]  wreg_q [NCH][1:7];
  logic [DW-1:0]  txd_q  [NCH];
  logic [DW-1:0]  rxd_q  [NCH];
  logic [NCH-1:0] txf_q, rxf_q, rxie, sel;

  wire start  = !iorq_n && !busy_q;
  wire hit    = addr[7:2] == BASE[7:2];
  wire io_rd  = start && m1_n && !rd_n && wr_n && hit;
  wire io_wr  = start && m1_n && !wr_n && hit;
  wire ack    = start && !m1_n;
  wire ctl    = addr[1];

  assign sel = addr[0] ? 2'b10 : 2'b01;

  for (genvar c = 0; c < NCH; c++) begin : g_out
    assign tx_data[c*DW +: DW] = txd_q[c];
    assign rxie[c] = |wreg_q[c][1][4:3];
  end

  assign tx_valid = txf_q;
  assign rx_ready = ~rxf_q;
  assign int_n    = ~|(rxf_q & rxie);
  assign doe      = hold_q;
  assign dout     = rdat_q;

  always_comb begin
    if (!ctl)
      rd_val = rxd_q[addr[0]];
    else if (ptr_q[addr[0]] == 3'd0)
      rd_val = {5'b0, ~txf_q[addr[0]], 1'b0, rxf_q[addr[0]]};
    else
      rd_val = wreg_q[addr[0]][ptr_q[addr[0]]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      rdat_q <= '0;
    end else begin
      busy_q <= !iorq_n;
      if (ack && !int_n) begin
        rdat_q <= wreg_q[VCH][2];
        hold_q <= 1'b1;
      end else if (io_rd) begin
        rdat_q <= rd_val;
        hold_q <= 1'b1;
      end else if (iorq_n) begin
        hold_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txf_q <= '0;
      rxf_q <= '0;
      for (int c = 0; c < NCH; c++) begin
        ptr_q[c] <= '0;
        txd_q[c] <= '0;
        rxd_q[c] <= '0;
        for (int r = 1; r < 8; r++) wreg_q[c][r] <= '0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (txf_q[c] && tx_ready[c]) txf_q[c] <= 1'b0;
        if (io_wr && sel[c] && !ctl && (!txf_q[c] || tx_ready[c])) begin
          txf_q[c] <= 1'b1;
          txd_q[c] <= din;
        end

        if (rxf_q[c] && io_rd && sel[c] && !ctl) rxf_q[c] <= 1'b0;
        if (!rxf_q[c] && rx_valid[c]) begin
          rxf_q[c] <= 1'b1;
          rxd_q[c] <= rx_data[c*DW +: DW];
        end

        if (io_rd && sel[c] && ctl) ptr_q[c] <= '0;
        if (io_wr && sel[c] && ctl) begin
          if (ptr_q[c] == 3'd0) begin
            if (din[5:3] == RST_CMD) begin
              ptr_q[c]     <= '0;
              wreg_q[c][1] <= '0;
              rxf_q[c]     <= 1'b0;
            end else begin
              ptr_q[c] <= din[2:0];
            end
          end else begin
            wreg_q[c][ptr_q[c]] <= din;
            ptr_q[c] <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sio_bus_emu_chk.sv
module sio_bus_emu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        iorq_n,
  input logic        m1_n,
  input logic        doe,
  input logic        int_n,
  input logic [15:0] tx_data,
  input logic [1:0]  tx_valid,
  input logic [1:0]  tx_ready,
  input logic [1:0]  rx_valid,
  input logic [1:0]  rx_ready
);
  p_doe_needs_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doe) |-> $past(!iorq_n));

  p_doe_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    iorq_n |=> !doe);

  p_int_needs_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !int_n |-> rx_ready != 2'b11);

  p_ack_needs_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(doe) && $past(!m1_n)) |-> $past(!int_n));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iorq_n && !m1_n) |=> !$rose(doe));

  for (genvar c = 0; c < 2; c++) begin : g_ch
    p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid[c] && !tx_ready[c]) |=> (tx_valid[c] && $stable(tx_data[c*8 +: 8])));

    p_rx_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid[c] && rx_ready[c] && iorq_n) |=> !rx_ready[c]);
  end
endmodule

bind sio_bus_emu sio_bus_emu_chk u_chk (.*);

// File: tb/sio_bus_emu_test.sv
`timescale 1ns/1ps
module sio_bus_emu_test;
  logic clk = 0, rst_n = 0;
  logic iorq_n = 1, rd_n = 1, wr_n = 1, m1_n = 1;
  logic [7:0] addr = 0, din = 0;
  logic [7:0] dout;
  logic doe, int_n;
  logic [15:0] tx_data, rx_data = 0;
  logic [1:0] tx_valid, tx_ready = 0, rx_valid = 0, rx_ready;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sio_bus_emu uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rr0(input bit txe, input bit rxr);
    return {5'b0, txe, 1'b0, rxr};
  endfunction

  task automatic io(input logic [7:0] a, input logic [7:0] d, input bit w,
                    output logic [7:0] q, output bit oe);
    @(negedge clk);
    addr = a; din = d; iorq_n = 0;
    if (w) wr_n = 0; else rd_n = 0;
    @(negedge clk);
    q = dout; oe = doe;
    iorq_n = 1; wr_n = 1; rd_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] q; bit oe;
    io(a, d, 1, q, oe);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] q);
    bit oe;
    io(a, 8'h00, 0, q, oe);
  endtask

  task automatic do_ack(output logic [7:0] q, output bit oe);
    @(negedge clk);
    m1_n = 0; iorq_n = 0;
    @(negedge clk);
    q = dout; oe = doe;
    m1_n = 1; iorq_n = 1;
    @(negedge clk);
  endtask

  task automatic push(input int ch, input logic [7:0] v);
    @(negedge clk);
    rx_valid[ch] = 1; rx_data[ch*8 +: 8] = v;
    @(negedge clk);
    rx_valid[ch] = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] q; bit oe;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(int_n == 1 && doe == 0 && tx_valid == 0 && rx_ready == 2'b11, "reset R7 R10",
        {int_n, doe, tx_valid, rx_ready}, 6'b100011);
    rd(8'h02, q);
    chk(q == rr0(1, 0), "reset status R4", q, rr0(1, 0));

    // R1: every address, read and write
    for (int a = 0; a < 256; a++) begin
      io(a[7:0], 8'h00, 0, q, oe);
      chk(oe == (a < 4), "R1 read decode", oe, a < 4);
      if (a >= 4) begin
        wr(a[7:0], a[7:0]);
        chk(tx_valid == 0, "R1 foreign write", tx_valid, 0);
      end
    end
    rd(8'h02, q);
    chk(q == rr0(1, 0), "R1 ptr untouched", q, rr0(1, 0));

    // R2: pointer then register, readback, pointer return
    for (int v = 0; v < 256; v += 17) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int r = 2; r < 8; r++) begin
          wr(8'h02 | ch[7:0], r[7:0]);
          wr(8'h02 | ch[7:0], (v + r) & 8'hff);
        end
        for (int r = 2; r < 8; r++) begin
          wr(8'h02 | ch[7:0], r[7:0]);
          rd(8'h02 | ch[7:0], q);
          chk(q == ((v + r) & 8'hff), "R2 readback", q, (v + r) & 8'hff);
        end
        rd(8'h02 | ch[7:0], q);
        chk(q == rr0(1, 0), "R2 ptr back to 0", q, rr0(1, 0));
      end
    end

    // R5/R4: transmit sweep
    for (int v = 0; v < 256; v++) begin
      int ch = v & 1;
      wr(ch[7:0], v[7:0]);
      chk(tx_valid[ch] && tx_data[ch*8 +: 8] == v[7:0], "R5 tx load", tx_data[ch*8 +: 8], v);
      rd(8'h02 | ch[7:0], q);
      chk(q == rr0(0, 0), "R4 tx busy", q, rr0(0, 0));
      @(negedge clk); tx_ready[ch] = 1;
      @(negedge clk); tx_ready[ch] = 0;
      chk(tx_valid[ch] == 0, "R5 tx drained", tx_valid[ch], 0);
      rd(8'h02 | ch[7:0], q);
      chk(q == rr0(1, 0), "R4 tx empty", q, rr0(1, 0));
    end
    wr(8'h00, 8'hAA);
    wr(8'h00, 8'h55);
    chk(tx_data[7:0] == 8'hAA, "R5 full write dropped", tx_data[7:0], 8'hAA);
    @(negedge clk);
    tx_ready[0] = 1; addr = 8'h00; din = 8'h3C; iorq_n = 0; wr_n = 0;
    @(negedge clk);
    tx_ready[0] = 0; iorq_n = 1; wr_n = 1;
    chk(tx_valid[0] && tx_data[7:0] == 8'h3C, "R5 drain and refill", tx_data[7:0], 8'h3C);
    @(negedge clk); tx_ready[0] = 1;
    @(negedge clk); tx_ready[0] = 0;
    chk(tx_valid[0] == 0, "R5 final drain", tx_valid[0], 0);

    // R6/R4: receive sweep
    for (int v = 0; v < 256; v++) begin
      int ch = (v >> 1) & 1;
      push(ch, v[7:0]);
      chk(rx_ready[ch] == 0, "R6 holder full", rx_ready[ch], 0);
      rd(8'h02 | ch[7:0], q);
      chk(q == rr0(1, 1), "R4 rx waiting", q, rr0(1, 1));
      rd(ch[7:0], q);
      chk(q == v[7:0], "R6 rx data", q, v);
      chk(rx_ready[ch] == 1, "R6 holder freed", rx_ready[ch], 1);
    end

    // R7: interrupt
    push(0, 8'h41);
    chk(int_n == 1, "R7 disabled", int_n, 1);
    rd(8'h00, q);
    wr(8'h02, 8'h01); wr(8'h02, 8'h18);
    push(0, 8'h42);
    chk(int_n == 0, "R7 raised", int_n, 0);
    rd(8'h00, q);
    chk(int_n == 1, "R7 released on read", int_n, 1);
    wr(8'h03, 8'h01); wr(8'h03, 8'h08);
    push(1, 8'h43);
    chk(int_n == 0, "R7 mode 01 on B", int_n, 0);
    rd(8'h01, q);
    wr(8'h03, 8'h01); wr(8'h03, 8'h00);

    // R8: acknowledge
    do_ack(q, oe);
    chk(oe == 0, "R8 no pending", oe, 0);
    for (int v = 0; v < 256; v += 15) begin
      wr(8'h03, 8'h02); wr(8'h03, v[7:0]);
      push(0, v[7:0]);
      do_ack(q, oe);
      chk(oe == 1 && q == v[7:0], "R8 vector", q, v);
      rd(8'h00, q);
    end

    // R3: channel reset
    push(0, 8'h55);
    chk(int_n == 0, "R3 setup", int_n, 0);
    wr(8'h02, 8'h18);
    chk(int_n == 1 && rx_ready[0] == 1, "R3 reset clears", {int_n, rx_ready[0]}, 2'b11);
    push(0, 8'h56);
    chk(int_n == 1, "R3 WR1 cleared", int_n, 1);
    rd(8'h00, q);
    wr(8'h03, 8'h1A);
    rd(8'h03, q);
    chk(q == rr0(1, 0), "R3 ptr cleared", q, rr0(1, 0));
    @(negedge clk);
    rx_valid[0] = 1; rx_data[7:0] = 8'h77; addr = 8'h02; din = 8'h18; iorq_n = 0; wr_n = 0;
    @(negedge clk);
    rx_valid[0] = 0; iorq_n = 1; wr_n = 1;
    @(negedge clk);
    chk(rx_ready[0] == 1, "R3 arrival on reset dropped", rx_ready[0], 1);
    rd(8'h02, q);
    chk(q == rr0(1, 0), "R3 status after collision", q, rr0(1, 0));

    // R9: fetch ignored
    push(0, 8'h61);
    @(negedge clk);
    m1_n = 0; rd_n = 0; addr = 8'h00;
    repeat (2) @(negedge clk);
    chk(doe == 0, "R9 no drive", doe, 0);
    m1_n = 1; rd_n = 1;
    @(negedge clk);
    rd(8'h02, q);
    chk(q == rr0(1, 1), "R9 byte kept", q, rr0(1, 1));
    rd(8'h00, q);
    chk(q == 8'h61, "R9 data intact", q, 8'h61);

    // R10: held read keeps captured value
    @(negedge clk);
    addr = 8'h02; iorq_n = 0; rd_n = 0;
    @(negedge clk);
    chk(doe == 1 && dout == rr0(1, 0), "R10 first", dout, rr0(1, 0));
    rx_valid[0] = 1; rx_data[7:0] = 8'h99;
    @(negedge clk);
    rx_valid[0] = 0;
    repeat (2) @(negedge clk);
    chk(doe == 1 && dout == rr0(1, 0), "R10 held", dout, rr0(1, 0));
    iorq_n = 1; rd_n = 1;
    @(negedge clk);
    chk(doe == 0, "R10 release", doe, 0);
    rd(8'h00, q);
    chk(q == 8'h99, "R10 later byte", q, 8'h99);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule